// File: doc/BRIEF.md
# Block Ring Index Tracker

This block keeps the bookkeeping for a small circular set of fixed-size block buffers that sit between a card data path and a host which moves whole blocks at a time. It moves no data. It tracks two ring positions: the slot the producer fills next and the slot the consumer drains next. It also raises sticky fault flags and tells the host when a slot is ready for it.

A transfer is armed in one of two directions. In receive mode the card side fills slots and the host pops them. In transmit mode the host pushes slots and the card side drains them. In both modes, when a position advances and lands on the other position, the block does not stall. It records a sticky collision fault: an overrun when receiving, an underrun (or the natural end of the stream) when transmitting. A separate sticky flag records any data-path error. In transmit mode a countdown of outstanding blocks marks the moment the buffer chain must be cut. In receive mode a completion output reports a clean transfer.

Top module: `blk_ring_tracker`

## Requirements
- R1: After reset both ring positions are 0, the status word is 0, and buf_avail, abort, rd_done and chain_last are low.
- R2: A one-cycle arm_rx or arm_tx pulse starts a transfer when arm_count is between 1 and 127. It sets status bit0 (receive) or bit1 (transmit), zeroes both positions and clears status bits 2 and 3. An arm is ignored when the count is 0 or above 127, or when both arm lines are high together.
- R3: In receive mode each blk_done pulse advances fill_idx by one modulo DEPTH. If the new fill_idx equals drain_idx, status bit2 (overrun) is set.
- R4: In receive mode a host_step pulse advances drain_idx by one modulo DEPTH only when drain_idx differs from fill_idx and abort is low. Otherwise it is ignored.
- R5: In transmit mode each blk_done pulse advances drain_idx by one modulo DEPTH. If the new drain_idx equals fill_idx, status bit2 (underrun) is set.
- R6: In transmit mode a host_step pulse advances fill_idx by one modulo DEPTH whenever abort is low, whatever drain_idx is. This allows DEPTH blocks to be pre-filled before the card side starts.
- R7: A dp_err pulse while a mode is active sets status bit3. While idle it has no effect.
- R8: Status bits 2 and 3 stay set until the next accepted arm or a stop pulse. A stop pulse returns the status word to 0 and lowers chain_last.
- R9: In transmit mode, pend_cnt loads arm_count on arm and decrements on each blk_done while it is non-zero. When it decrements to exactly DEPTH, chain_last goes high and stays high.
- R10: rd_done is high in receive mode exactly when the number of accepted host pops equals the armed count and status bits 2 and 3 are clear.
- R11: abort equals status bit2 OR bit3. buf_avail is high only when a mode is active, the two positions differ, and abort is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_rx | input | 1 | Arm a receive transfer |
| arm_tx | input | 1 | Arm a transmit transfer |
| arm_count | input | CNT_W | Block count for the arm |
| stop | input | 1 | Close the transfer and clear status |
| blk_done | input | 1 | Card side finished one block |
| host_step | input | 1 | Host popped (receive) or pushed (transmit) one block |
| dp_err | input | 1 | Data-path error event |
| fill_idx | output | IW | Slot written next |
| drain_idx | output | IW | Slot read next |
| status | output | 4 | {error, collision, transmit, receive} |
| pend_cnt | output | CNT_W | Outstanding transmit blocks |
| chain_last | output | 1 | Buffer chain must terminate after current slot |
| buf_avail | output | 1 | A slot is ready for the host |
| abort | output | 1 | Sticky fault present |
| rd_done | output | 1 | Receive finished cleanly |

## Verification
The bench drives the receive ring until the fill position wraps onto the drain position. A design that compared the old index, or that stalled instead of flagging, would leave the overrun bit clear and buf_avail high. It pops an empty ring and pops after an abort: a tracker that did not gate the pop would move drain_idx past data that never arrived. In transmit mode the bench pre-fills all DEPTH slots so that fill_idx wraps back to 0, then drains until the underrun. It watches the countdown pass through DEPTH, because an off-by-one compare would cut the chain one block early or late. Rejected arm counts (0, 128) and a double arm must leave the status at 0. After a fault, a re-arm must clear it, and a dp_err while idle must not set it.

// File: rtl/blk_ring_tracker.sv
module blk_ring_tracker #(
  parameter int DEPTH    = 4,
  parameter int CNT_W    = 8,
  parameter int MAX_BLKS = 127,
  localparam int IW      = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_rx,
  input  logic             arm_tx,
  input  logic [CNT_W-1:0] arm_count,
  input  logic             stop,
  input  logic             blk_done,
  input  logic             host_step,
  input  logic             dp_err,
  output logic [IW-1:0]    fill_idx,
  output logic [IW-1:0]    drain_idx,
  output logic [3:0]       status,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             chain_last,
  output logic             buf_avail,
  output logic             abort,
  output logic             rd_done
);

  logic             rx_mode, tx_mode, xrun, err;
  logic [CNT_W-1:0] blks, pops;
  logic [IW-1:0]    fill_n, drain_n;
  logic             active, arm_go, pop_ok, push_ok, collide;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign active  = rx_mode | tx_mode;
  assign abort   = xrun | err;
  assign status  = {err, xrun, tx_mode, rx_mode};
  assign arm_go  = !stop && (arm_rx ^ arm_tx) && (arm_count != '0)
                   && (arm_count <= CNT_W'(MAX_BLKS));
  assign pop_ok  = rx_mode && host_step && (drain_idx != fill_idx) && !abort;
  assign push_ok = tx_mode && host_step && !abort;

  assign fill_n  = ((rx_mode && blk_done) || push_ok) ? nxt(fill_idx) : fill_idx;
  assign drain_n = ((tx_mode && blk_done) || pop_ok) ? nxt(drain_idx) : drain_idx;
  assign collide = active && blk_done && (fill_n == drain_n);

  assign buf_avail = active && (fill_idx != drain_idx) && !abort;
  assign rd_done   = rx_mode && (pops == blks) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mode <= 1'b0; tx_mode <= 1'b0; xrun <= 1'b0; err <= 1'b0;
      fill_idx <= '0; drain_idx <= '0;
      blks <= '0; pops <= '0; pend_cnt <= '0; chain_last <= 1'b0;
    end else if (stop) begin
      rx_mode <= 1'b0; tx_mode <= 1'b0; xrun <= 1'b0; err <= 1'b0;
      chain_last <= 1'b0;
    end else if (arm_go) begin
      rx_mode    <= arm_rx;
      tx_mode    <= arm_tx;
      xrun       <= 1'b0;
      err        <= 1'b0;
      fill_idx   <= '0;
      drain_idx  <= '0;
      blks       <= arm_count;
      pops       <= '0;
      pend_cnt   <= arm_tx ? arm_count : '0;
      chain_last <= 1'b0;
    end else if (active) begin
      fill_idx  <= fill_n;
      drain_idx <= drain_n;
      if (collide) xrun <= 1'b1;
      if (dp_err)  err  <= 1'b1;
      if (pop_ok)  pops <= pops + 1'b1;
      if (tx_mode && blk_done && pend_cnt != '0) begin
        pend_cnt <= pend_cnt - 1'b1;
        if (pend_cnt - 1'b1 == CNT_W'(DEPTH)) chain_last <= 1'b1;
      end
    end
  end

  assert_one_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[1:0]));

  assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && blk_done && !stop && !arm_go) |=>
      (fill_idx == nxt($past(fill_idx))));

  assert_pop_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode && host_step && (drain_idx == fill_idx) && !stop && !arm_go) |=>
      $stable(drain_idx));

  assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && blk_done && !stop && !arm_go) |=>
      (drain_idx == nxt($past(drain_idx))));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dp_err && !stop && !arm_go) |=> status[3]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !stop && !arm_go) |=> abort);

  assert_pend_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && blk_done && pend_cnt != '0 && !stop && !arm_go) |=>
      (pend_cnt == $past(pend_cnt) - 1'b1));

endmodule

// File: tb/blk_ring_tracker_bench.sv
module blk_ring_tracker_bench;
  localparam int DEPTH = 4;
  localparam int CW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm_rx = 0, arm_tx = 0, stop = 0, blk_done = 0, host_step = 0, dp_err = 0;
  logic [CW-1:0] arm_count = '0;
  logic [1:0] fill_idx, drain_idx;
  logic [3:0] status;
  logic [CW-1:0] pend_cnt;
  logic chain_last, buf_avail, abort, rd_done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  blk_ring_tracker #(.DEPTH(DEPTH), .CNT_W(CW), .MAX_BLKS(127)) u_blk_ring_tracker (
    .clk(clk), .rst_n(rst_n), .arm_rx(arm_rx), .arm_tx(arm_tx), .arm_count(arm_count),
    .stop(stop), .blk_done(blk_done), .host_step(host_step), .dp_err(dp_err),
    .fill_idx(fill_idx), .drain_idx(drain_idx), .status(status), .pend_cnt(pend_cnt),
    .chain_last(chain_last), .buf_avail(buf_avail), .abort(abort), .rd_done(rd_done));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic rx, input logic tx, input int cnt, input logic st,
                       input logic bd, input logic hs, input logic de);
    arm_rx = rx; arm_tx = tx; arm_count = CW'(cnt); stop = st;
    blk_done = bd; host_step = hs; dp_err = de;
    @(negedge clk);
    arm_rx = 0; arm_tx = 0; stop = 0; blk_done = 0; host_step = 0; dp_err = 0;
  endtask

  task automatic t_reset;
    chk("R1 fill", fill_idx, 0); chk("R1 drain", drain_idx, 0);
    chk("R1 status", status, 0); chk("R1 avail", buf_avail, 0);
    chk("R1 abort", abort, 0); chk("R1 done", rd_done, 0);
    chk("R1 chain", chain_last, 0);
  endtask

  task automatic t_arm_reject;
    pulse(1, 0, 0, 0, 0, 0, 0);   chk("R2 count0", status, 0);
    pulse(1, 0, 128, 0, 0, 0, 0); chk("R2 count128", status, 0);
    pulse(1, 1, 3, 0, 0, 0, 0);   chk("R2 both", status, 0);
  endtask

  task automatic t_read_flow;
    pulse(1, 0, 3, 0, 0, 0, 0);
    chk("R2 arm rx", status, 4'b0001); chk("R2 idx", fill_idx, 0);
    chk("R11 avail empty", buf_avail, 0);
    pulse(0, 0, 0, 0, 0, 1, 0); chk("R4 empty pop", drain_idx, 0);
    pulse(0, 0, 0, 0, 1, 0, 0); pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R3 fill", fill_idx, 2); chk("R11 avail", buf_avail, 1);
    pulse(0, 0, 0, 0, 0, 1, 0); pulse(0, 0, 0, 0, 0, 1, 0);
    chk("R4 drain", drain_idx, 2); chk("R10 not yet", rd_done, 0);
    pulse(0, 0, 0, 0, 1, 0, 0); pulse(0, 0, 0, 0, 0, 1, 0);
    chk("R4 drain3", drain_idx, 3); chk("R10 done", rd_done, 1);
    chk("R3 no overrun", status, 4'b0001);
  endtask

  task automatic t_overrun;
    pulse(1, 0, 10, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R3 pre-wrap", status, 4'b0001);
    pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R3 wrap idx", fill_idx, 0); chk("R3 overrun", status, 4'b0101);
    chk("R11 abort", abort, 1); chk("R11 avail off", buf_avail, 0);
    pulse(0, 0, 0, 0, 1, 0, 0); pulse(0, 0, 0, 0, 0, 1, 0);
    chk("R4 pop after abort", drain_idx, 0); chk("R8 sticky", status[2], 1);
    chk("R10 no done", rd_done, 0);
    pulse(0, 0, 0, 1, 0, 0, 0); chk("R8 stop", status, 0);
  endtask

  task automatic t_write;
    pulse(0, 1, 6, 0, 0, 0, 0);
    chk("R2 arm tx", status, 4'b0010); chk("R9 load", pend_cnt, 6);
    for (int i = 0; i < 4; i++) pulse(0, 0, 0, 0, 0, 1, 0);
    chk("R6 prefill wrap", fill_idx, 0); chk("R11 full", buf_avail, 0);
    pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R5 drain", drain_idx, 1); chk("R9 dec", pend_cnt, 5);
    chk("R5 no underrun", status, 4'b0010); chk("R9 chain early", chain_last, 0);
    pulse(0, 0, 0, 0, 0, 1, 0); chk("R6 push", fill_idx, 1);
    pulse(0, 0, 0, 0, 1, 0, 0); chk("R9 chain", chain_last, 1);
    pulse(0, 0, 0, 0, 1, 0, 0); pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R5 before end", status, 4'b0010);
    pulse(0, 0, 0, 0, 1, 0, 0);
    chk("R5 underrun", status, 4'b0110); chk("R9 pend", pend_cnt, 1);
    pulse(0, 0, 0, 0, 0, 1, 0); chk("R6 push blocked", fill_idx, 1);
    pulse(0, 0, 0, 1, 0, 0, 0); chk("R8 stop chain", chain_last, 0);
  endtask

  task automatic t_error;
    pulse(0, 0, 0, 0, 0, 0, 1); chk("R7 idle err", status, 0);
    pulse(1, 0, 2, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 0, 1); chk("R7 err", status, 4'b1001);
    chk("R11 abort err", abort, 1);
    pulse(1, 0, 2, 0, 0, 0, 0); chk("R8 rearm clears", status, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_arm_reject;
    t_read_flow;
    t_overrun;
    t_write;
    t_error;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule